// File: doc/BRIEF.md
# Clock start-up delay sequencer

This block keeps the system clock gated off, and the internal reset asserted, until the oscillator has had time to settle after a reset or after a wake-up from a low-power state. It runs on the oscillator clock it guards. A slow tick from an independent watchdog oscillator times the long millisecond part of the delay. After a reset it first counts a fixed number of oscillator cycles. Then, depending on a 2-bit start-up code, it waits for a number of slow ticks. Only when both parts are done does it open the clock gate and release the internal reset together.

Once the system runs, a sleep request closes the gate and keeps the reset released. A later wake-up request reopens the gate after a short fixed cycle count, whatever the start-up code is. The code selects between three cases: brown-out detection active (no time-out), fast-rising power (short time-out) and slowly rising power (long time-out). The fourth code value is reserved and is treated as the longest case. The watchdog tick is asynchronous to the oscillator clock and passes through a two-flop synchronizer before it is counted.

Top module: `sut_startup_seq`

## Requirements
- R1: While `arst_n` is low, or at any clock edge where `rst_src` is sampled high, both `clk_en` and `rst_rel` are low from that edge on, in every state.
- R2: With code 2'b00, if `rst_src` is first sampled low at clock edge E, then `clk_en` and `rst_rel` both rise at edge E+14 (parameter RST_CYC) and not before.
- R3: With code 2'b01, the reset release also needs SHORT_TICKS (default 512) rising edges of `wdt_tick`. Only rising edges that arrive after the 14-cycle phase has ended are counted.
- R4: With code 2'b10, the reset release needs LONG_TICKS (default 8192) rising edges of `wdt_tick` after the 14-cycle phase. SHORT_TICKS edges are not enough.
- R5: Code 2'b11 behaves exactly like code 2'b10.
- R6: `wdt_tick` is asynchronous. Each low-to-high transition counts once, however long the high level lasts, provided that each level is held for at least two oscillator cycles.
- R7: The code is captured at the edge where `rst_src` is first sampled low. Later changes of `sut_code` have no effect on that start-up.
- R8: While running, `sleep_req` sampled high makes `clk_en` fall at that edge while `rst_rel` stays high. `clk_en` is never high while `rst_rel` is low.
- R9: While asleep, if `wake_req` is first sampled high at edge W, `clk_en` rises at edge W+6 (parameter WAKE_CYC), for any code, and `rst_rel` stays high throughout.
- R10: `sleep_req` has no effect unless the system is running, and `wake_req` has no effect while the system is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock being gated |
| arst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| sut_code | input | 2 | Start-up code: 00 brown-out, 01 fast power, 10 slow power, 11 reserved |
| rst_src | input | 1 | High while a reset source is active |
| sleep_req | input | 1 | Request to enter the low-power state |
| wake_req | input | 1 | Request to wake from the low-power state |
| wdt_tick | input | 1 | Slow tick from the watchdog oscillator, asynchronous |
| clk_en | output | 1 | System clock gate enable |
| rst_rel | output | 1 | Internal reset release, high when reset is released |

## Verification
The hardest situation to reach is a watchdog tick that arrives while the 14-cycle phase is still counting. That tick must be ignored, even though the tick count is already known. The bench sends one full tick immediately after it releases `rst_src`, so that the synchronized rising edge falls inside the cycle-count phase. It then shows that one tick fewer than the required count after the phase still leaves the system held, and that one more releases it. Ticks held high for many cycles are used to confirm that each level change counts only once.

// File: rtl/sut_seq_pkg.sv
package sut_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD    = 3'd0,
        ST_RSTCNT  = 3'd1,
        ST_MSCNT   = 3'd2,
        ST_RUN     = 3'd3,
        ST_SLEEP   = 3'd4,
        ST_WAKECNT = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        SUT_BOD  = 2'b00,
        SUT_FAST = 2'b01,
        SUT_SLOW = 2'b10,
        SUT_RSVD = 2'b11
    } sut_code_e;

endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick_async,
    output logic tick_rise
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SW-2:0], tick_async};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // rising edge seen at the output of the synchronizer chain
    assign tick_rise = sh_q[SW-2] & ~sh_q[SW-1];

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!arst_n)
        tick_rise |=> !tick_rise);

endmodule

// File: rtl/sut_delay_select.sv
module sut_delay_select
    import sut_seq_pkg::*;
#(
    parameter int SHORT_TICKS = 512,
    parameter int LONG_TICKS  = 8192,
    parameter int TW          = 14
) (
    input  logic [1:0]    code,
    output logic          need_ms,
    output logic [TW-1:0] target
);
    always_comb begin
        unique case (sut_code_e'(code))
            SUT_BOD: begin
                need_ms = 1'b0;
                target  = '0;
            end
            SUT_FAST: begin
                need_ms = 1'b1;
                target  = TW'(SHORT_TICKS);
            end
            default: begin  // slow power and reserved share the longest wait
                need_ms = 1'b1;
                target  = TW'(LONG_TICKS);
            end
        endcase
    end
endmodule

// File: rtl/sut_startup_seq.sv
module sut_startup_seq
    import sut_seq_pkg::*;
#(
    parameter int RST_CYC     = 14,
    parameter int WAKE_CYC    = 6,
    parameter int SHORT_TICKS = 512,
    parameter int LONG_TICKS  = 8192,
    parameter int SYNC_STAGES = 2
) (
    input  logic       osc_clk,
    input  logic       arst_n,
    input  logic [1:0] sut_code,
    input  logic       rst_src,
    input  logic       sleep_req,
    input  logic       wake_req,
    input  logic       wdt_tick,
    output logic       clk_en,
    output logic       rst_rel
);
    localparam int CYC_MAX = (RST_CYC > WAKE_CYC) ? RST_CYC : WAKE_CYC;
    localparam int CW      = $clog2(CYC_MAX + 1);
    localparam int TW      = $clog2(LONG_TICKS + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cyc;
        logic [TW-1:0] ticks;
        logic [1:0]    code;
        logic          en;
        logic          rel;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic          tick_rise;
    logic          need_ms;
    logic [TW-1:0] target;

    tick_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (osc_clk),
        .arst_n     (arst_n),
        .tick_async (wdt_tick),
        .tick_rise  (tick_rise)
    );

    sut_delay_select #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS),
        .TW          (TW)
    ) u_sel (
        .code    (r_q.code),
        .need_ms (need_ms),
        .target  (target)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_HOLD: begin
                r_d.state = ST_RSTCNT;
                r_d.cyc   = '0;
                r_d.code  = sut_code;
            end
            ST_RSTCNT: begin
                if (r_q.cyc == CW'(RST_CYC - 1)) begin
                    r_d.cyc   = '0;
                    r_d.ticks = '0;
                    r_d.state = need_ms ? ST_MSCNT : ST_RUN;
                end else begin
                    r_d.cyc = r_q.cyc + CW'(1);
                end
            end
            ST_MSCNT: begin
                if (tick_rise) begin
                    if (r_q.ticks == target - TW'(1)) r_d.state = ST_RUN;
                    else                              r_d.ticks = r_q.ticks + TW'(1);
                end
            end
            ST_RUN: begin
                if (sleep_req) r_d.state = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_req) begin
                    r_d.state = ST_WAKECNT;
                    r_d.cyc   = '0;
                end
            end
            ST_WAKECNT: begin
                if (r_q.cyc == CW'(WAKE_CYC - 1)) r_d.state = ST_RUN;
                else                              r_d.cyc   = r_q.cyc + CW'(1);
            end
            default: r_d.state = ST_HOLD;
        endcase

        if (rst_src) begin
            r_d.state = ST_HOLD;
            r_d.cyc   = '0;
            r_d.ticks = '0;
        end

        r_d.en  = (r_d.state == ST_RUN);
        r_d.rel = (r_d.state == ST_RUN) || (r_d.state == ST_SLEEP) ||
                  (r_d.state == ST_WAKECNT);
    end

    always_ff @(posedge osc_clk or negedge arst_n) begin
        if (!arst_n) begin
            r_q.state <= ST_HOLD;
            r_q.cyc   <= '0;
            r_q.ticks <= '0;
            r_q.code  <= SUT_RSVD;
            r_q.en    <= 1'b0;
            r_q.rel   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_en  = r_q.en;
    assign rst_rel = r_q.rel;

    // Assertions
    p_src_holds_r1: assert property (@(posedge osc_clk) disable iff (!arst_n)
        rst_src |=> (!clk_en && !rst_rel));

    p_rel_drop_cause_r1: assert property (@(posedge osc_clk) disable iff (!arst_n)
        $fell(rst_rel) |-> $past(rst_src));

    p_rst_count_bound_r2: assert property (@(posedge osc_clk) disable iff (!arst_n)
        (r_q.state == ST_RSTCNT) |-> (r_q.cyc < CW'(RST_CYC)));

    p_ms_needs_code_r3: assert property (@(posedge osc_clk) disable iff (!arst_n)
        (r_q.state == ST_MSCNT) |-> (r_q.code != SUT_BOD));

    p_tick_bound_r4: assert property (@(posedge osc_clk) disable iff (!arst_n)
        r_q.ticks < TW'(LONG_TICKS));

    p_code_stable_r7: assert property (@(posedge osc_clk) disable iff (!arst_n)
        (r_q.state != ST_HOLD) |=> $stable(r_q.code) || $past(rst_src));

    p_enable_needs_release_r8: assert property (@(posedge osc_clk) disable iff (!arst_n)
        clk_en |-> rst_rel);

    p_sleep_gate_r8: assert property (@(posedge osc_clk) disable iff (!arst_n)
        (clk_en && sleep_req && !rst_src) |=> (!clk_en && rst_rel));

    p_wake_count_bound_r9: assert property (@(posedge osc_clk) disable iff (!arst_n)
        (r_q.state == ST_WAKECNT) |-> (r_q.cyc < CW'(WAKE_CYC)));

    p_run_ignores_wake_r10: assert property (@(posedge osc_clk) disable iff (!arst_n)
        (clk_en && !sleep_req && !rst_src) |=> clk_en);

endmodule

// File: tb/sim_sut_startup_seq.sv
module sim_sut_startup_seq;

    localparam int SHORT_T = 16;
    localparam int LONG_T  = 64;
    localparam int NV      = 8;

    // entry: {code[1:0], ticks[7:0], expected release}
    localparam logic [10:0] VEC [NV] = '{
        {2'b00, 8'd0,  1'b1},
        {2'b01, 8'd15, 1'b0},
        {2'b01, 8'd16, 1'b1},
        {2'b10, 8'd63, 1'b0},
        {2'b10, 8'd64, 1'b1},
        {2'b11, 8'd63, 1'b0},
        {2'b11, 8'd64, 1'b1},
        {2'b10, 8'd16, 1'b0}
    };

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic [1:0] sut_code = 2'b00;
    logic       rst_src = 1'b1;
    logic       sleep_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       clk_en, rst_rel;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sut_startup_seq #(
        .SHORT_TICKS (SHORT_T),
        .LONG_TICKS  (LONG_T)
    ) u0 (
        .osc_clk   (osc_clk_w),
        .arst_n    (arst_n),
        .sut_code  (sut_code),
        .rst_src   (rst_src),
        .sleep_req (sleep_req),
        .wake_req  (wake_req),
        .wdt_tick  (wdt_tick),
        .clk_en    (clk_en),
        .rst_rel   (rst_rel)
    );

    wire osc_clk_w = clk;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic start_reset(input logic [1:0] code);
        rst_src = 1'b1;
        cyc(1);
        sut_code = code;
        rst_src  = 1'b0;
    endtask

    task automatic send_tick();
        wdt_tick = 1'b1;
        cyc(4);
        wdt_tick = 1'b0;
        cyc(4);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        cyc(2);
        chk("R1 clk_en in reset", clk_en, 1'b0);
        chk("R1 rst_rel in reset", rst_rel, 1'b0);
        arst_n = 1'b1;
        cyc(2);
        chk("R1 held by rst_src", rst_rel, 1'b0);

        // table of start-up codes and tick counts (R3, R4, R5)
        for (int i = 0; i < NV; i++) begin
            start_reset(VEC[i][10:9]);
            cyc(15);
            repeat (int'(VEC[i][8:1])) send_tick();
            cyc(4);
            chk($sformatf("R3/R4/R5 vec %0d rst_rel", i), rst_rel, VEC[i][0]);
            chk($sformatf("R3/R4/R5 vec %0d clk_en", i), clk_en, VEC[i][0]);
        end

        // R2: exact 14-cycle release for code 00
        start_reset(2'b00);
        cyc(14);
        chk("R2 still held at E+13", rst_rel, 1'b0);
        chk("R2 gate closed at E+13", clk_en, 1'b0);
        cyc(1);
        chk("R2 released at E+14", rst_rel, 1'b1);
        chk("R2 gate open at E+14", clk_en, 1'b1);

        // R1: reset source while running
        rst_src = 1'b1;
        cyc(1);
        chk("R1 run to reset clk_en", clk_en, 1'b0);
        chk("R1 run to reset rst_rel", rst_rel, 1'b0);

        // R7: code changes after capture are ignored
        start_reset(2'b00);
        cyc(2);
        sut_code = 2'b10;
        cyc(12);
        chk("R7 code 00 held at E+13", rst_rel, 1'b0);
        cyc(1);
        chk("R7 code 00 kept after change", rst_rel, 1'b1);
        start_reset(2'b10);
        cyc(1);
        sut_code = 2'b00;
        cyc(14);
        chk("R7 code 10 kept after change", rst_rel, 1'b0);
        sut_code = 2'b01;

        // R3: tick during cycle phase is not counted
        start_reset(2'b01);
        send_tick();
        cyc(7);
        repeat (SHORT_T - 1) send_tick();
        cyc(4);
        chk("R3 early tick ignored", rst_rel, 1'b0);
        send_tick();
        cyc(4);
        chk("R3 release after full count", rst_rel, 1'b1);

        // R10: wake request while running has no effect
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        cyc(2);
        chk("R10 wake in run ignored", clk_en, 1'b1);

        // R8: sleep closes gate, keeps reset released
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
        chk("R8 sleep clk_en", clk_en, 1'b0);
        chk("R8 sleep rst_rel", rst_rel, 1'b1);

        // R9: wake takes 6 cycles
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        cyc(5);
        chk("R9 gate closed at W+5", clk_en, 1'b0);
        chk("R9 rst_rel during wake", rst_rel, 1'b1);
        cyc(1);
        chk("R9 gate open at W+6", clk_en, 1'b1);

        // R10: sleep during reset cycle count has no effect
        start_reset(2'b00);
        cyc(2);
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
        cyc(11);
        chk("R10 sleep in count held", clk_en, 1'b0);
        cyc(1);
        chk("R10 sleep in count ignored", clk_en, 1'b1);

        // R6: long high level counts once
        start_reset(2'b01);
        cyc(15);
        wdt_tick = 1'b1;
        cyc(40);
        wdt_tick = 1'b0;
        cyc(4);
        repeat (SHORT_T - 2) send_tick();
        cyc(4);
        chk("R6 long tick counted once", rst_rel, 1'b0);
        send_tick();
        cyc(4);
        chk("R6 release after count", rst_rel, 1'b1);

        // R9: wake length independent of code 10
        start_reset(2'b10);
        cyc(15);
        repeat (LONG_T) send_tick();
        cyc(4);
        sleep_req = 1'b1;
        cyc(1);
        sleep_req = 1'b0;
        cyc(3);
        wake_req = 1'b1;
        cyc(1);
        wake_req = 1'b0;
        cyc(5);
        chk("R9 code 10 gate closed at W+5", clk_en, 1'b0);
        cyc(1);
        chk("R9 code 10 gate open at W+6", clk_en, 1'b1);

        summary();
        $finish;
    end

endmodule